// File: doc/BRIEF.md
# Sideband Doorbell Mailbox Bridge

This block sits between a host register port and an internal sideband message bus. The host fills an address register and a data register, then writes a command word to a doorbell register. An accepted doorbell write packs the target selector, opcode, byte enables and base-region index into one request and sends it to the sideband side. A busy flag in the doorbell register stays set until the target answers.

The sideband side has a valid/ready request channel and a valid-only completion channel. When busy clears after a read opcode, the data register holds the value the target returned. After a write opcode, the data register keeps the value the host stored. Host software polls the busy bit before it starts a new transaction and again before it collects a read result.

The doorbell word layout is as follows. Bits [31:24] are the device/function, [23:16] the opcode, [15:8] the target port, [7:4] the byte enables and [3:1] the base-region index. Bit [0] reads back as busy and is ignored on a write.

Top module: `sb_doorbell_bridge`

## Requirements
- R1: After reset, busy is 0, reqValid is 0, and the address, data and doorbell registers read back as 0.
- R2: With busy clear, a host write with hostSel 0 loads the address register and one with hostSel 1 loads the data register. hostRdData shows the selected register combinationally: 0 address, 1 data, 2 doorbell, 3 reads as zero.
- R3: A doorbell write (hostSel 2) with busy clear sets busy and raises reqValid one cycle later. The request carries port = word[15:8], opcode = word[23:16], byte enables = word[7:4], devfn = word[31:24], base index = word[3:1], the address register and the data register. The doorbell readback returns word[31:1] with busy in bit 0.
- R4: reqValid stays asserted with a stable payload until a cycle where reqReady is 1. It drops after that one accepted beat, so each doorbell yields exactly one request.
- R5: Busy stays set from the doorbell write until a completion (cplValid) is sampled after the request was accepted. It reads 0 starting the cycle after that completion.
- R6: For opcodes 0x00 and 0x06 (reads), cplData is loaded into the data register in the cycle busy clears.
- R7: Every other opcode (0x01, 0x07 and any unlisted value) is a write. The data register keeps the host value after the completion.
- R8: While busy is set, host writes to any register are ignored. They launch no request and change no register.
- R9: A completion that arrives while no request is outstanding is discarded and leaves the data register unchanged. This covers the idle state and the time before the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 address, 1 data, 2 doorbell |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Readback of the selected register |
| reqValid | output | 1 | Sideband request valid |
| reqReady | input | 1 | Sideband request accepted |
| reqDevFn | output | 8 | Request device/function |
| reqOpcode | output | 8 | Request opcode |
| reqPort | output | 8 | Request target port |
| reqByteEn | output | 4 | Request byte enables |
| reqBar | output | 3 | Request base-region index |
| reqAddr | output | ADDR_W | Request address |
| reqWrData | output | DATA_W | Request write data |
| cplValid | input | 1 | Completion strobe |
| cplData | input | DATA_W | Completion read data |

## Verification
A corrupted control state shows up at the ports at the next clock edge. A stuck or skipped phase changes reqValid or bit 0 of the doorbell readback within one cycle of the doorbell write, the handshake or the completion. A bad register update shows up in the readback of the chosen register or in the request payload in the cycle after the update. The bench therefore compares reqValid, the full payload and the selected readback against a reference model at every falling edge. Directed checks cover held requests, stray completions and writes made while busy.

// File: rtl/sbdb_pkg.sv
package sbdb_pkg;

  localparam int DOOR_W   = 32;
  localparam int DEVFN_LO = 24;
  localparam int OP_LO    = 16;
  localparam int PORT_LO  = 8;
  localparam int BE_LO    = 4;
  localparam int BAR_LO   = 1;
  localparam int FIELD_W  = 8;
  localparam int BE_W     = 4;
  localparam int BAR_W    = 3;

  localparam logic [FIELD_W-1:0] OP_MEM_RD  = 8'h00;
  localparam logic [FIELD_W-1:0] OP_PRIV_RD = 8'h06;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DOOR = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic loadCmd;
    logic loadCpl;
  } strobes_t;

  typedef struct packed {
    logic [FIELD_W-1:0] devFn;
    logic [FIELD_W-1:0] opcode;
    logic [FIELD_W-1:0] port;
    logic [BE_W-1:0]    byteEn;
    logic [BAR_W-1:0]   bar;
  } cmd_t;

  function automatic logic opIsRead(input logic [FIELD_W-1:0] op);
    return (op == OP_MEM_RD) || (op == OP_PRIV_RD);
  endfunction

endpackage

// File: rtl/sbdb_ctrl.sv
module sbdb_ctrl
  import sbdb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostWrEn,
  input  logic [1:0] hostSel,
  input  logic     reqReady,
  input  logic     cplValid,
  input  logic     cmdIsRead,
  output strobes_t strobes,
  output logic     busy,
  output logic     reqValid
);

  phase_t phaseQ, phaseD;
  logic   idle;
  logic   wrOk;

  assign idle = (phaseQ == ST_IDLE);
  assign wrOk = hostWrEn && idle;

  always_comb begin
    strobes.loadAddr = wrOk && (hostSel == SEL_ADDR);
    strobes.loadData = wrOk && (hostSel == SEL_DATA);
    strobes.loadCmd  = wrOk && (hostSel == SEL_DOOR);
    strobes.loadCpl  = (phaseQ == ST_WAIT) && cplValid && cmdIsRead;
  end

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      ST_IDLE: if (strobes.loadCmd) phaseD = ST_REQ;
      ST_REQ:  if (reqReady)        phaseD = ST_WAIT;
      ST_WAIT: if (cplValid)        phaseD = ST_IDLE;
      default:                      phaseD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= ST_IDLE;
    else       phaseQ <= phaseD;
  end

  assign busy     = !idle;
  assign reqValid = (phaseQ == ST_REQ);

endmodule

// File: rtl/sbdb_datapath.sv
module sbdb_datapath
  import sbdb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              busy,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] cplData,
  output logic [DATA_W-1:0] hostRdData,
  output cmd_t              cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              cmdIsRead
);

  localparam int PAD_A = DATA_W - ADDR_W;
  localparam int PAD_D = DATA_W - DOOR_W;

  logic [DOOR_W-1:0] doorWord;
  cmd_t              cmdIn;

  always_comb begin
    cmdIn.devFn  = hostWrData[DEVFN_LO +: FIELD_W];
    cmdIn.opcode = hostWrData[OP_LO    +: FIELD_W];
    cmdIn.port   = hostWrData[PORT_LO  +: FIELD_W];
    cmdIn.byteEn = hostWrData[BE_LO    +: BE_W];
    cmdIn.bar    = hostWrData[BAR_LO   +: BAR_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      cmdQ  <= '0;
    end else begin
      if (strobes.loadAddr) addrQ <= hostWrData[ADDR_W-1:0];
      if (strobes.loadData) dataQ <= hostWrData;
      else if (strobes.loadCpl) dataQ <= cplData;
      if (strobes.loadCmd) cmdQ <= cmdIn;
    end
  end

  assign cmdIsRead = opIsRead(cmdQ.opcode);
  assign doorWord  = {cmdQ.devFn, cmdQ.opcode, cmdQ.port, cmdQ.byteEn, cmdQ.bar, busy};

  generate
    if (PAD_A > 0) begin : g_padAddr
      logic [DATA_W-1:0] addrWide;
      assign addrWide = {{PAD_A{1'b0}}, addrQ};
      if (PAD_D > 0) begin : g_padDoor
        always_comb begin
          unique case (hostSel)
            SEL_ADDR: hostRdData = addrWide;
            SEL_DATA: hostRdData = dataQ;
            SEL_DOOR: hostRdData = {{PAD_D{1'b0}}, doorWord};
            default:  hostRdData = '0;
          endcase
        end
      end else begin : g_fullDoor
        always_comb begin
          unique case (hostSel)
            SEL_ADDR: hostRdData = addrWide;
            SEL_DATA: hostRdData = dataQ;
            SEL_DOOR: hostRdData = doorWord;
            default:  hostRdData = '0;
          endcase
        end
      end
    end else begin : g_fullAddr
      if (PAD_D > 0) begin : g_padDoor
        always_comb begin
          unique case (hostSel)
            SEL_ADDR: hostRdData = addrQ;
            SEL_DATA: hostRdData = dataQ;
            SEL_DOOR: hostRdData = {{PAD_D{1'b0}}, doorWord};
            default:  hostRdData = '0;
          endcase
        end
      end else begin : g_fullDoor
        always_comb begin
          unique case (hostSel)
            SEL_ADDR: hostRdData = addrQ;
            SEL_DATA: hostRdData = dataQ;
            SEL_DOOR: hostRdData = doorWord;
            default:  hostRdData = '0;
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sb_doorbell_bridge.sv
module sb_doorbell_bridge
  import sbdb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [7:0]        reqDevFn,
  output logic [7:0]        reqOpcode,
  output logic [7:0]        reqPort,
  output logic [3:0]        reqByteEn,
  output logic [2:0]        reqBar,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWrData,
  input  logic              cplValid,
  input  logic [DATA_W-1:0] cplData
);

  strobes_t          strobes;
  cmd_t              cmdReg;
  logic              busyFlag;
  logic              cmdIsRead;
  logic [DATA_W-1:0] dataReg;

  sbdb_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostSel  (hostSel),
    .reqReady (reqReady),
    .cplValid (cplValid),
    .cmdIsRead(cmdIsRead),
    .strobes  (strobes),
    .busy     (busyFlag),
    .reqValid (reqValid)
  );

  sbdb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busy      (busyFlag),
    .hostSel   (hostSel),
    .hostWrData(hostWrData),
    .cplData   (cplData),
    .hostRdData(hostRdData),
    .cmdQ      (cmdReg),
    .addrQ     (reqAddr),
    .dataQ     (dataReg),
    .cmdIsRead (cmdIsRead)
  );

  assign reqDevFn  = cmdReg.devFn;
  assign reqOpcode = cmdReg.opcode;
  assign reqPort   = cmdReg.port;
  assign reqByteEn = cmdReg.byteEn;
  assign reqBar    = cmdReg.bar;
  assign reqWrData = dataReg;

endmodule

// File: rtl/sbdb_checker.sv
module sbdb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [1:0]        hostSel,
  input logic              reqValid,
  input logic              reqReady,
  input logic [7:0]        reqOpcode,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWrData,
  input logic              cplValid,
  input logic              busy,
  input logic [DATA_W-1:0] dataQ
);

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostWrEn && hostSel == 2'd2) |=> (busy && reqValid)); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqOpcode) && $stable(reqWrData))); // R4

  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqValid); // R4

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy); // R5

  AST_CPL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !reqValid && cplValid) |=> !busy); // R5

  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !reqValid && cplValid && reqOpcode != 8'h00 && reqOpcode != 8'h06) |=> $stable(dataQ)); // R7

  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn) |=> $stable(reqAddr) && $stable(reqOpcode)); // R8

  AST_STRAY_CPL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cplValid && !hostWrEn) |=> $stable(dataQ)); // R9

endmodule

bind sb_doorbell_bridge sbdb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWrEn (hostWrEn),
  .hostSel  (hostSel),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqOpcode(reqOpcode),
  .reqAddr  (reqAddr),
  .reqWrData(reqWrData),
  .cplValid (cplValid),
  .busy     (busyFlag),
  .dataQ    (dataReg)
);

// File: tb/tb_sb_doorbell_bridge.sv
`timescale 1ns/1ps
module tb_sb_doorbell_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [7:0]  reqDevFn, reqOpcode, reqPort;
  logic [3:0]  reqByteEn;
  logic [2:0]  reqBar;
  logic [31:0] reqAddr, reqWrData;
  logic        cplValid = 1'b0;
  logic [31:0] cplData = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sb_doorbell_bridge dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqDevFn(reqDevFn), .reqOpcode(reqOpcode),
    .reqPort(reqPort), .reqByteEn(reqByteEn), .reqBar(reqBar),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .cplValid(cplValid),
    .cplData(cplData)
  );

  // reference model: 0 idle, 1 request pending, 2 awaiting completion
  int          mPhase = 0;
  logic [31:0] mAddr = '0;
  logic [31:0] mData = '0;
  logic [31:0] mCmd = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mPhase <= 0; mAddr <= '0; mData <= '0; mCmd <= '0;
    end else begin
      case (mPhase)
        0: if (hostWrEn) begin
             if (hostSel == 2'd0) mAddr <= hostWrData;
             if (hostSel == 2'd1) mData <= hostWrData;
             if (hostSel == 2'd2) begin
               mCmd <= {hostWrData[31:1], 1'b0};
               mPhase <= 1;
             end
           end
        1: if (reqReady) mPhase <= 2;
        default: if (cplValid) begin
             mPhase <= 0;
             if (mCmd[23:16] == 8'h00 || mCmd[23:16] == 8'h06) mData <= cplData;
           end
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] expRd;
    check("R4 reqValid", {31'b0, reqValid}, {31'b0, mPhase == 1});
    if (mPhase == 1) begin
      check("R3 payload port/op/be", {8'h0, reqOpcode, reqPort, 4'h0, reqByteEn},
            {8'h0, mCmd[23:16], mCmd[15:8], 4'h0, mCmd[7:4]});
      check("R3 payload devfn/bar", {21'h0, reqBar, reqDevFn}, {21'h0, mCmd[3:1], mCmd[31:24]});
      check("R3 payload addr", reqAddr, mAddr);
      check("R3 payload wdata", reqWrData, mData);
    end
    case (hostSel)
      2'd0: expRd = mAddr;
      2'd1: expRd = mData;
      2'd2: expRd = {mCmd[31:1], mPhase != 0};
      default: expRd = '0;
    endcase
    check("R2 readback model", hostRdData, expRd);
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); #1;
    hostSel = sel; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk); #1;
    hostSel = sel;
    @(negedge clk);
    v = hostRdData;
  endtask

  task automatic complete(input logic [31:0] d);
    @(negedge clk); #1;
    cplValid = 1'b1; cplData = d;
    @(negedge clk); #1;
    cplValid = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idleCycles(2);
    #1 rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, v); check("R1 addr after reset", v, 32'h0);
    readReg(2'd1, v); check("R1 data after reset", v, 32'h0);
    readReg(2'd2, v); check("R1 doorbell after reset", v, 32'h0);
    check("R1 reqValid after reset", {31'b0, reqValid}, 32'h0);

    // R2 register loads and readback
    hostWrite(2'd0, 32'h1234_5678);
    hostWrite(2'd1, 32'hDEAD_BEEF);
    readReg(2'd0, v); check("R2 addr", v, 32'h1234_5678);
    readReg(2'd1, v); check("R2 data", v, 32'hDEAD_BEEF);
    readReg(2'd3, v); check("R2 unused select", v, 32'h0);

    // private read, target slow to accept
    reqReady = 1'b0;
    hostWrite(2'd2, {8'h00, 8'h06, 8'h11, 4'hF, 3'd0, 1'b0});
    check("R3 reqValid after doorbell", {31'b0, reqValid}, 32'h1);
    check("R3 request port", {24'h0, reqPort}, 32'h11);
    hostWrite(2'd2, {8'h00, 8'h01, 8'h22, 4'h3, 3'd0, 1'b0});   // R8 ignored
    hostWrite(2'd0, 32'hAAAA_AAAA);                               // R8 ignored
    complete(32'hBBBB_BBBB);                                      // R9 before accept
    check("R4 still held", {31'b0, reqValid}, 32'h1);
    readReg(2'd1, v); check("R9 stray before accept", v, 32'hDEAD_BEEF);
    readReg(2'd2, v); check("R8 doorbell unchanged", v, {8'h00, 8'h06, 8'h11, 4'hF, 3'd0, 1'b1});
    #1 reqReady = 1'b1;
    @(negedge clk); #1 reqReady = 1'b0;
    idleCycles(2);
    check("R4 dropped after beat", {31'b0, reqValid}, 32'h0);
    readReg(2'd2, v); check("R5 busy until completion", {31'b0, v[0]}, 32'h1);
    complete(32'hCAFE_0001);
    readReg(2'd1, v); check("R6 read data loaded", v, 32'hCAFE_0001);
    readReg(2'd2, v); check("R5 busy cleared", {31'b0, v[0]}, 32'h0);
    readReg(2'd0, v); check("R8 addr unchanged", v, 32'h1234_5678);

    // private write: data kept
    reqReady = 1'b1;
    hostWrite(2'd1, 32'h0BAD_F00D);
    hostWrite(2'd2, {8'h08, 8'h07, 8'h33, 4'hF, 3'd2, 1'b1});
    idleCycles(2);
    complete(32'h5555_5555);
    readReg(2'd1, v); check("R7 write keeps data", v, 32'h0BAD_F00D);

    // memory read
    hostWrite(2'd0, 32'h0000_0040);
    hostWrite(2'd2, {8'h10, 8'h00, 8'h44, 4'hF, 3'd0, 1'b0});
    idleCycles(1);
    complete(32'h1357_2468);
    readReg(2'd1, v); check("R6 memory read", v, 32'h1357_2468);

    // memory write and unlisted opcode
    hostWrite(2'd2, {8'h10, 8'h01, 8'h45, 4'h3, 3'd0, 1'b0});
    complete(32'h7777_0000);
    readReg(2'd1, v); check("R7 memory write", v, 32'h1357_2468);
    hostWrite(2'd2, {8'h10, 8'h05, 8'h46, 4'hF, 3'd0, 1'b0});
    complete(32'h6666_0000);
    readReg(2'd1, v); check("R7 unlisted opcode", v, 32'h1357_2468);

    // idle completion
    complete(32'h9999_9999);
    readReg(2'd1, v); check("R9 idle completion", v, 32'h1357_2468);
    readReg(2'd2, v); check("R9 stays idle", {31'b0, v[0]}, 32'h0);

    idleCycles(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule